// File: doc/BRIEF.md
# Byte-Wide Bus Address Decoder

This block sits between a processor's data-memory port and a non-multiplexed byte-wide bus. Each cycle it looks at a 16-bit address together with a data-access flag and a write request. It then produces registered, active-low enables for on-board memory and for two off-board peripherals, plus one active-low write strobe. Memory and peripherals share that strobe.

When the peripheral-select input is set, the upper half of the address space is carved into two 16 KB peripheral windows, decoded from the top two address bits only. The lower 14 address bits are passed to the peripherals. A boundary register marks the bottom of the space as program region. Reads there still reach memory, but the write strobe is never asserted for it. While the system is in its reset state, every enable and the strobe stay inactive.

Top module: `byte_bus_decoder`

## Requirements
- R1: While `rst_n` is low, `memEn_n`, `periphLoEn_n`, `periphHiEn_n` and `wrStrobe_n` are 1 and `periphAddr` is 0.
- R2: With `periphSel` = 1, a data access to 8000h–BFFFh (top address bits 2'b10) drives `periphLoEn_n` low and leaves `memEn_n` and `periphHiEn_n` high.
- R3: With `periphSel` = 1, a data access to C000h–FFFFh (top address bits 2'b11) drives `periphHiEn_n` low and leaves `memEn_n` and `periphLoEn_n` high.
- R4: With `periphSel` = 0, every data access, including addresses at or above 8000h, drives `memEn_n` low and leaves both peripheral enables high.
- R5: With `periphSel` = 1, a data access below 8000h drives `memEn_n` low.
- R6: A data access with `writeReq` = 1 and address >= `progBound` drives `wrStrobe_n` low, whether the target is memory or a peripheral.
- R7: A write request to an address < `progBound` leaves `wrStrobe_n` high, while the decoded enable is still asserted. With `progBound` = 0, no address is protected.
- R8: While `inReset` = 1, all enables and `wrStrobe_n` are held high, whatever the other inputs are.
- R9: When `dataAccess` = 0, all enables and `wrStrobe_n` are high.
- R10: At most one of `memEn_n`, `periphLoEn_n` and `periphHiEn_n` is low in any cycle.
- R11: All outputs are registered. They reflect the inputs sampled at the previous rising clock edge, and `periphAddr` equals the lower 14 bits of that sampled address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Data-memory address |
| dataAccess | input | 1 | A data access is requested this cycle |
| writeReq | input | 1 | The access is a write |
| periphSel | input | 1 | Enables the two peripheral windows |
| progBound | input | 16 | Addresses below this value are program region |
| inReset | input | 1 | System reset state; forces all outputs inactive |
| memEn_n | output | 1 | On-board memory enable, active low |
| periphLoEn_n | output | 1 | Peripheral enable for 8000h–BFFFh, active low |
| periphHiEn_n | output | 1 | Peripheral enable for C000h–FFFFh, active low |
| wrStrobe_n | output | 1 | Shared write strobe, active low |
| periphAddr | output | 14 | Lower address bits forwarded to peripherals |

## Verification
The bench probes the window edges 7FFFh/8000h, BFFFh/C000h and FFFFh. A decoder that compares more or fewer top bits would enable the wrong device or memory at one of these edges. It writes exactly at `progBound`, one byte below it, and with `progBound` = 0. An off-by-one or inverted comparison would either block a legal write or strobe a protected byte. It also asserts `inReset` and drops `dataAccess` while every other input requests a write to a peripheral, so any leak of an enable or strobe shows at the ports. One vector checks that outputs hold their old values just after new inputs are applied, which catches a combinational path that bypasses the registers.

// File: rtl/byte_bus_decoder_pkg.sv
package byte_bus_decoder_pkg;
  // Number of peripheral windows carved from the upper address space.
  localparam int PERIPH_CNT = 2;
  // First window index (in units of the top-bit slice) that is a peripheral.
  localparam int PERIPH_BASE = 2;

  // Strobes handed from the decode control to the output datapath.
  typedef struct packed {
    logic                  memSel;
    logic [PERIPH_CNT-1:0] periSel;
    logic                  wrOk;
  } decStrobe_t;
endpackage

// File: rtl/byte_bus_decode_ctrl.sv
module byte_bus_decode_ctrl
  import byte_bus_decoder_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              dataAccess,
  input  logic              writeReq,
  input  logic              periphSel,
  input  logic [ADDR_W-1:0] progBound,
  input  logic              inReset,
  output decStrobe_t        strobe
);
  logic [WIN_W-1:0]      winIdx;
  logic [PERIPH_CNT-1:0] periHit;
  logic                  accessLive;
  logic                  inProgRegion;
  logic                  anyPeri;

  assign winIdx = busAddr[ADDR_W-1 -: WIN_W];

  // One comparator per peripheral window on the top address bits.
  for (genvar k = 0; k < PERIPH_CNT; k++) begin : g_window
    localparam logic [WIN_W-1:0] WinCode = WIN_W'(PERIPH_BASE + k);
    assign periHit[k] = periphSel && (winIdx == WinCode);
  end

  always_comb begin
    accessLive     = dataAccess && !inReset;
    inProgRegion   = busAddr < progBound;
    anyPeri        = |periHit;
    strobe.memSel  = accessLive && !anyPeri;
    strobe.periSel = accessLive ? periHit : '0;
    strobe.wrOk    = accessLive && writeReq && !inProgRegion;
  end
endmodule

// File: rtl/byte_bus_out_regs.sv
module byte_bus_out_regs
  import byte_bus_decoder_pkg::*;
#(
  parameter int PADDR_W = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  decStrobe_t         strobe,
  input  logic [PADDR_W-1:0] lowAddr,
  output logic               memEn_n,
  output logic               periphLoEn_n,
  output logic               periphHiEn_n,
  output logic               wrStrobe_n,
  output logic [PADDR_W-1:0] periphAddr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      memEn_n      <= 1'b1;
      periphLoEn_n <= 1'b1;
      periphHiEn_n <= 1'b1;
      wrStrobe_n   <= 1'b1;
      periphAddr   <= '0;
    end else begin
      memEn_n      <= !strobe.memSel;
      periphLoEn_n <= !strobe.periSel[0];
      periphHiEn_n <= !strobe.periSel[1];
      wrStrobe_n   <= !strobe.wrOk;
      periphAddr   <= lowAddr;
    end
  end
endmodule

// File: rtl/byte_bus_decoder.sv
module byte_bus_decoder
  import byte_bus_decoder_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int WIN_W = 2,
  localparam int PADDR_W = ADDR_W - WIN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               dataAccess,
  input  logic               writeReq,
  input  logic               periphSel,
  input  logic [ADDR_W-1:0]  progBound,
  input  logic               inReset,
  output logic               memEn_n,
  output logic               periphLoEn_n,
  output logic               periphHiEn_n,
  output logic               wrStrobe_n,
  output logic [PADDR_W-1:0] periphAddr
);
  decStrobe_t strobe;

  byte_bus_decode_ctrl #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) ctrl_i (
    .busAddr(busAddr), .dataAccess(dataAccess), .writeReq(writeReq),
    .periphSel(periphSel), .progBound(progBound), .inReset(inReset),
    .strobe(strobe)
  );

  byte_bus_out_regs #(.PADDR_W(PADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .lowAddr(busAddr[PADDR_W-1:0]),
    .memEn_n(memEn_n), .periphLoEn_n(periphLoEn_n),
    .periphHiEn_n(periphHiEn_n), .wrStrobe_n(wrStrobe_n),
    .periphAddr(periphAddr)
  );
endmodule

// File: rtl/byte_bus_decoder_chk.sv
module byte_bus_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int PADDR_W = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               dataAccess,
  input logic               writeReq,
  input logic               periphSel,
  input logic [ADDR_W-1:0]  progBound,
  input logic               inReset,
  input logic               memEn_n,
  input logic               periphLoEn_n,
  input logic               periphHiEn_n,
  input logic               wrStrobe_n,
  input logic [PADDR_W-1:0] periphAddr
);
  logic live;
  assign live = dataAccess && !inReset;

  // R10
  a_r10_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!memEn_n, !periphLoEn_n, !periphHiEn_n}));

  // R8
  a_r8_reset_state_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(inReset) |->
      (memEn_n && periphLoEn_n && periphHiEn_n && wrStrobe_n));

  // R7
  a_r7_program_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(writeReq && (busAddr < progBound)) |-> wrStrobe_n);

  // R2
  a_r2_low_window: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(live && periphSel && busAddr[ADDR_W-1 -: 2] == 2'b10) |->
      (!periphLoEn_n && memEn_n && periphHiEn_n));

  // R3
  a_r3_high_window: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(live && periphSel && busAddr[ADDR_W-1 -: 2] == 2'b11) |->
      (!periphHiEn_n && memEn_n && periphLoEn_n));

  // R9
  a_r9_no_access_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!dataAccess) |->
      (memEn_n && periphLoEn_n && periphHiEn_n && wrStrobe_n));

  // R11
  a_r11_addr_forward: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> periphAddr == $past(busAddr[PADDR_W-1:0]));
endmodule

bind byte_bus_decoder byte_bus_decoder_chk #(.ADDR_W(ADDR_W), .PADDR_W(PADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .dataAccess(dataAccess),
  .writeReq(writeReq), .periphSel(periphSel), .progBound(progBound),
  .inReset(inReset), .memEn_n(memEn_n), .periphLoEn_n(periphLoEn_n),
  .periphHiEn_n(periphHiEn_n), .wrStrobe_n(wrStrobe_n), .periphAddr(periphAddr)
);

// File: tb/byte_bus_decoder_tb.sv
module byte_bus_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] busAddr = '0;
  logic        dataAccess = 1'b0;
  logic        writeReq = 1'b0;
  logic        periphSel = 1'b0;
  logic [15:0] progBound = '0;
  logic        inReset = 1'b0;
  logic        memEn_n, periphLoEn_n, periphHiEn_n, wrStrobe_n;
  logic [13:0] periphAddr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  byte_bus_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .dataAccess(dataAccess),
    .writeReq(writeReq), .periphSel(periphSel), .progBound(progBound),
    .inReset(inReset), .memEn_n(memEn_n), .periphLoEn_n(periphLoEn_n),
    .periphHiEn_n(periphHiEn_n), .wrStrobe_n(wrStrobe_n), .periphAddr(periphAddr)
  );

  task automatic checkOut(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {memEn_n, periphLoEn_n, periphHiEn_n, wrStrobe_n};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {mem,lo,hi,wr} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic checkAddr(input string req, input logic [13:0] exp);
    checks++;
    if (periphAddr !== exp) begin
      fails++;
      $display("FAIL %s: periphAddr actual %h expected %h", req, periphAddr, exp);
    end
  endtask

  // Apply one access, then sample one cycle later (R11 latency), also checking R10.
  task automatic access(input string req, input logic [15:0] a, input logic da,
                        input logic wr, input logic ps, input logic rs,
                        input logic [3:0] exp);
    @(negedge clk);
    busAddr = a; dataAccess = da; writeReq = wr; periphSel = ps; inReset = rs;
    @(negedge clk);
    checkOut(req, exp);
    checkAddr("R11", a[13:0]);
    checks++;
    if ($countones({!memEn_n, !periphLoEn_n, !periphHiEn_n}) > 1) begin
      fails++;
      $display("FAIL R10: enables %b expected at most one low",
               {memEn_n, periphLoEn_n, periphHiEn_n});
    end
  endtask

  task automatic t_reset;
    busAddr = 16'hC123; dataAccess = 1'b1; writeReq = 1'b1; periphSel = 1'b1;
    #22;
    checkOut("R1", 4'b1111);
    checkAddr("R1", 14'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_windows;
    progBound = 16'h0000;
    access("R2", 16'h8000, 1, 0, 1, 0, 4'b1011);
    access("R2", 16'hBFFF, 1, 0, 1, 0, 4'b1011);
    access("R3", 16'hC000, 1, 0, 1, 0, 4'b1101);
    access("R3", 16'hFFFF, 1, 0, 1, 0, 4'b1101);
    access("R5", 16'h7FFF, 1, 0, 1, 0, 4'b0111);
  endtask

  task automatic t_plainMemory;
    access("R4", 16'h9000, 1, 0, 0, 0, 4'b0111);
    access("R4", 16'hE000, 1, 0, 0, 0, 4'b0111);
  endtask

  task automatic t_writes;
    progBound = 16'h4000;
    access("R6", 16'h4000, 1, 1, 0, 0, 4'b0110);
    access("R6", 16'h8123, 1, 1, 1, 0, 4'b1010);
    access("R7", 16'h3FFF, 1, 1, 0, 0, 4'b0111);
    progBound = 16'h0000;
    access("R7", 16'h0000, 1, 1, 0, 0, 4'b0110);
    progBound = 16'hC000;
    access("R6", 16'hD000, 1, 1, 1, 0, 4'b1100);
    access("R7", 16'hA000, 1, 1, 1, 0, 4'b1011);
  endtask

  task automatic t_resetState;
    progBound = 16'h0000;
    access("R8", 16'hC000, 1, 1, 1, 1, 4'b1111);
    access("R8", 16'h1234, 1, 1, 0, 1, 4'b1111);
  endtask

  task automatic t_idle;
    access("R9", 16'h8000, 0, 1, 1, 0, 4'b1111);
    access("R9", 16'h0100, 0, 1, 0, 0, 4'b1111);
  endtask

  task automatic t_latency;
    access("R11", 16'h0055, 1, 1, 0, 0, 4'b0110);
    @(negedge clk);
    busAddr = 16'hC0AA; dataAccess = 1'b0; writeReq = 1'b0; periphSel = 1'b1;
    #1;
    checkOut("R11", 4'b0110);
    checkAddr("R11", 14'h0055);
    @(negedge clk);
    checkOut("R11", 4'b1111);
    checkAddr("R11", 14'h00AA);
  endtask

  initial begin
    t_reset();
    t_windows();
    t_plainMemory();
    t_writes();
    t_resetState();
    t_idle();
    t_latency();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule